// File: doc/BRIEF.md
# Byte-Window GPIO Pin Controller

This block presents a bank of general-purpose pins through a 48-byte register window. Every access moves exactly one byte. The low part of the window is a read-only group of level bytes. The rest holds one control byte per pin. Each control byte carries three bits that matter:

- an output value in bit 0,
- a sampled input level in bit 1,
- an output-enable in bit 2.

When software writes a control byte with output-enable set, the written output value is looped back into the input bit. When output-enable is clear, the input bit keeps the level last seen on the pin.

External pin inputs are resynchronised by a two-flop chain. Only a change seen after the chain updates the input bit.

Two pins also drive interrupt lines:

- one pin acts as an active-low level interrupt;
- a second pin follows its input upward and downward.

A non-maskable request strobe forces that second pin high for one clock and then low again, which gives a single one-cycle interrupt pulse. An input change on a pin whose output is enabled is still taken, and it raises a one-cycle conflict flag.

Top module: `gpio_bytewin`

## Requirements
- R1: Offsets 0 to 7 (level bytes) and offsets 44 to 47 read as 0x00, and bus writes to them change no readable byte.
- R2: The control byte of pin n sits at offset 8+n. It reads back bits 7..3, bit 2 and bit 0 exactly as last written.
- R3: On a control-byte write, written bit 1 is discarded. If written bit 2 (output-enable) is 1, bit 1 takes written bit 0. Otherwise bit 1 keeps its previous value.
- R4: A pin input change becomes visible in bit 1 of that pin's byte on the third rising clock edge after the change, and not before. An input that does not change bit 1 has no effect.
- R5: An input change that flips bit 1 of a pin whose bit 2 is 1 is still applied. The drive_conflict output is 1 for exactly the one cycle after that update.
- R6: irq_out[1] is active-low. It goes to 1 in the same cycle that an input event sets pin 1's bit 1 to 0, and it goes to 0 when an input event sets that bit to 1.
- R7: irq_out[9] goes to 1 in the cycle that an input event sets pin 9's bit 1 to 1, and it goes to 0 when an input event sets that bit to 0.
- R8: A rising edge on nmi_req makes irq_out[9] and pin 9's bit 1 equal to 1 for exactly one cycle, after which both return to 0.
- R9: irq_out lines other than 1 and 9 stay 0 whatever the input activity.
- R10: After reset, pin 1's control byte reads 0x02, every other byte reads 0x00, and irq_out and drive_conflict are 0.
- R11: Bus writes never change irq_out, even when the loopback changes bit 1 of pin 1 or pin 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Byte offset into the register window |
| bus_we | input | 1 | Write strobe for one byte |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Read data byte for bus_addr (combinational) |
| pin_in | input | 36 | Asynchronous external pin levels |
| nmi_req | input | 1 | Non-maskable request; its rising edge starts the pulse |
| irq_out | output | 10 | Interrupt lines, index 0 to 9 |
| drive_conflict | output | 1 | One-cycle flag: input changed on an output-enabled pin |

## Verification
The bench builds the block with its default parameters: 36 pins, 8 level bytes, 10 interrupt lines, the level interrupt on pin 1 and the pulse interrupt on pin 9. With these values every decode boundary can be reached:

- the last level byte;
- the first and the last control byte (pin 0 and pin 35);
- the unmapped tail at 44 to 47.

Both fixed-polarity pins and the non-maskable pulse can be exercised as well. Input timing is checked on both sides of the three-edge latency, so a synchroniser that is too short or too long shows up.

// File: rtl/gpio_bw_pkg.sv
package gpio_bw_pkg;
  localparam int BIT_OUT = 0;
  localparam int BIT_IN  = 1;
  localparam int BIT_OE  = 2;

  // bus write merge: bit IN is never taken from the bus data
  function automatic logic [7:0] merge_write(input logic [7:0] old_b,
                                              input logic [7:0] wdat);
    logic [7:0] r;
    r = wdat;
    r[BIT_IN] = wdat[BIT_OE] ? wdat[BIT_OUT] : old_b[BIT_IN];
    return r;
  endfunction
endpackage

// File: rtl/gpio_bw_sync.sv
module gpio_bw_sync #(
  parameter int W      = 36,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) stg_q[k] <= '0;
    end else begin
      stg_q[0] <= din;
      for (int k = 1; k < STAGES; k++) stg_q[k] <= stg_q[k-1];
    end
  end

  assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_bw_ctrl_byte.sv
module gpio_bw_ctrl_byte
  import gpio_bw_pkg::*;
#(
  parameter logic [7:0] RST_VAL = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_sel,
  input  logic [7:0] wr_data,
  input  logic       evt,
  input  logic       evt_val,
  output logic [7:0] ctrl_q,
  output logic       chg,
  output logic       conflict_q
);
  logic [7:0] ctrl_d;
  logic       conflict_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_sel) ctrl_d = merge_write(ctrl_q, wr_data);
    chg = evt && (evt_val != ctrl_q[BIT_IN]);
    if (chg) ctrl_d[BIT_IN] = evt_val;
    conflict_d = chg && ctrl_q[BIT_OE];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= RST_VAL;
      conflict_q <= 1'b0;
    end else begin
      ctrl_q     <= ctrl_d;
      conflict_q <= conflict_d;
    end
  end

  p_keep_in_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sel && !wr_data[BIT_OE] && !evt) |=> ctrl_q[BIT_IN] == $past(ctrl_q[BIT_IN]));

  p_loopback_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sel && wr_data[BIT_OE] && !evt) |=> ctrl_q[BIT_IN] == $past(wr_data[BIT_OUT]));

  p_conflict_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && ctrl_q[BIT_OE] && (evt_val != ctrl_q[BIT_IN])) |=> (conflict_q && ctrl_q[BIT_IN] == $past(evt_val)));
endmodule

// File: rtl/gpio_bw_irq.sv
module gpio_bw_irq #(
  parameter int NUM_IRQ   = 10,
  parameter int LVL_PIN   = 1,
  parameter int PULSE_PIN = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] chg,
  input  logic [NUM_IRQ-1:0] val,
  output logic [NUM_IRQ-1:0] irq
);
  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
    if (i == LVL_PIN || i == PULSE_PIN) begin : g_act
      logic irq_q, irq_d;
      always_comb begin
        irq_d = irq_q;
        if (chg[i]) irq_d = (i == LVL_PIN) ? !val[i] : val[i];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= irq_d;
      end
      assign irq[i] = irq_q;
    end else begin : g_idle
      assign irq[i] = 1'b0;
    end
  end

  p_level_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    chg[LVL_PIN] |=> irq[LVL_PIN] == !$past(val[LVL_PIN]));

  p_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    chg[PULSE_PIN] |=> irq[PULSE_PIN] == $past(val[PULSE_PIN]));

  p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (chg == '0) |=> $stable(irq));
endmodule

// File: rtl/gpio_bytewin.sv
module gpio_bytewin
  import gpio_bw_pkg::*;
#(
  parameter int NUM_PINS    = 36,
  parameter int LVL_BYTES   = 8,
  parameter int WIN_BYTES   = 48,
  parameter int NUM_IRQ     = 10,
  parameter int LVL_PIN     = 1,
  parameter int PULSE_PIN   = 9,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W     = $clog2(WIN_BYTES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [7:0]          bus_wdata,
  output logic [7:0]          bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic                nmi_req,
  output logic [NUM_IRQ-1:0]  irq_out,
  output logic                drive_conflict
);
  localparam int CTRL_END = LVL_BYTES + NUM_PINS;

  logic [NUM_PINS-1:0] pin_s, pin_prev_q, pin_edge;
  logic [NUM_PINS-1:0] evt, evt_val, chg, conf;
  logic [NUM_PINS-1:0] wr_sel;
  logic [7:0]          ctrl_arr [NUM_PINS];
  logic [ADDR_W-1:0]   ctrl_off;
  logic                in_ctrl;
  logic                nmi_prev_q, nmi_stb, nmi_pend_q;

  // input path
  gpio_bw_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pin_in), .dout(pin_s)
  );

  // NMI strobe and pulse tail
  assign nmi_stb = nmi_req && !nmi_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_prev_q <= '0;
      nmi_prev_q <= 1'b0;
      nmi_pend_q <= 1'b0;
    end else begin
      pin_prev_q <= pin_s;
      nmi_prev_q <= nmi_req;
      nmi_pend_q <= nmi_stb;
    end
  end

  assign pin_edge = pin_s ^ pin_prev_q;

  // address decode
  assign in_ctrl  = (bus_addr >= ADDR_W'(LVL_BYTES)) && (bus_addr < ADDR_W'(CTRL_END));
  assign ctrl_off = bus_addr - ADDR_W'(LVL_BYTES);

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    if (i == PULSE_PIN) begin : g_nmi
      assign evt[i]     = pin_edge[i] || nmi_stb || nmi_pend_q;
      assign evt_val[i] = nmi_stb ? 1'b1 : (nmi_pend_q ? 1'b0 : pin_s[i]);
    end else begin : g_plain
      assign evt[i]     = pin_edge[i];
      assign evt_val[i] = pin_s[i];
    end

    assign wr_sel[i] = bus_we && in_ctrl && (ctrl_off == ADDR_W'(i));

    gpio_bw_ctrl_byte #(
      .RST_VAL((i == LVL_PIN) ? 8'h02 : 8'h00)
    ) u_byte (
      .clk(clk), .rst_n(rst_n),
      .wr_sel(wr_sel[i]), .wr_data(bus_wdata),
      .evt(evt[i]), .evt_val(evt_val[i]),
      .ctrl_q(ctrl_arr[i]), .chg(chg[i]), .conflict_q(conf[i])
    );
  end

  // read mux: level bytes and unmapped tail read zero
  always_comb begin
    bus_rdata = 8'h00;
    for (int i = 0; i < NUM_PINS; i++) begin
      if (in_ctrl && ctrl_off == ADDR_W'(i)) bus_rdata = ctrl_arr[i];
    end
  end

  assign drive_conflict = |conf;

  gpio_bw_irq #(
    .NUM_IRQ(NUM_IRQ), .LVL_PIN(LVL_PIN), .PULSE_PIN(PULSE_PIN)
  ) u_irq (
    .clk(clk), .rst_n(rst_n),
    .chg(chg[NUM_IRQ-1:0]), .val(evt_val[NUM_IRQ-1:0]),
    .irq(irq_out)
  );

  p_nmi_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_stb |=> (irq_out[PULSE_PIN] && ctrl_arr[PULSE_PIN][BIT_IN]));

  p_nmi_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_pend_q && !nmi_stb) |=> (!irq_out[PULSE_PIN] && !ctrl_arr[PULSE_PIN][BIT_IN]));

  p_other_lines_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(irq_out) == $countones({irq_out[LVL_PIN], irq_out[PULSE_PIN]}));

  p_zero_tail_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ctrl |-> bus_rdata == 8'h00);
endmodule

// File: tb/gpio_bytewin_tb.sv
module gpio_bytewin_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [35:0] pin_in = 36'h2;
  logic        nmi_req = 1'b0;
  logic [9:0]  irq_out;
  logic        drive_conflict;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  gpio_bytewin dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .nmi_req(nmi_req), .irq_out(irq_out), .drive_conflict(drive_conflict)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(6'd9, v);  chk("R10 pin1 byte", v, 8'h02);
    rd(6'd8, v);  chk("R10 pin0 byte", v, 8'h00);
    rd(6'd43, v); chk("R10 pin35 byte", v, 8'h00);
    chk("R10 irq", irq_out, 10'h0);
    chk("R10 conflict", drive_conflict, 1'b0);
  endtask

  task automatic t_window;
    logic [7:0] v;
    wr(6'd7, 8'hFF);  rd(6'd7, v);  chk("R1 level byte 7", v, 8'h00);
    wr(6'd0, 8'h5A);  rd(6'd0, v);  chk("R1 level byte 0", v, 8'h00);
    wr(6'd45, 8'hFF); rd(6'd45, v); chk("R1 tail 45", v, 8'h00);
    rd(6'd8, v);  chk("R1 pin0 untouched", v, 8'h00);
    rd(6'd43, v); chk("R1 pin35 untouched", v, 8'h00);
  endtask

  task automatic t_write;
    logic [7:0] v;
    wr(6'd11, 8'h07); rd(6'd11, v); chk("R3 loopback 1", v, 8'h07);
    wr(6'd11, 8'h03); rd(6'd11, v); chk("R3 keep bit1", v, 8'h03);
    wr(6'd11, 8'hF8); rd(6'd11, v); chk("R3 keep high bits", v, 8'hFA);
    wr(6'd11, 8'h06); rd(6'd11, v); chk("R3 loopback 0", v, 8'h04);
    wr(6'd28, 8'hA9); rd(6'd28, v); chk("R2 pin20", v, 8'hA9);
    wr(6'd43, 8'h55); rd(6'd43, v); chk("R2 pin35", v, 8'h57);
    wr(6'd8, 8'h80);  rd(6'd8, v);  chk("R2 pin0", v, 8'h80);
  endtask

  task automatic t_input;
    @(negedge clk);
    bus_addr = 6'd13;
    pin_in[5] = 1'b1;
    edges(2); chk("R4 not before 3rd edge", bus_rdata, 8'h00);
    edges(1); chk("R4 at 3rd edge", bus_rdata, 8'h02);
    chk("R5 no conflict without OE", drive_conflict, 1'b0);
    chk("R9 pin5 no irq", irq_out, 10'h0);
    @(negedge clk); pin_in[0] = 1'b1;
    edges(4); chk("R9 pin0 no irq", irq_out, 10'h0);
  endtask

  task automatic t_conflict;
    wr(6'd15, 8'h04);
    @(negedge clk);
    bus_addr = 6'd15;
    pin_in[7] = 1'b1;
    edges(2); chk("R5 conflict early", drive_conflict, 1'b0);
    edges(1); chk("R5 applied with OE", bus_rdata, 8'h06);
    chk("R5 conflict pulse", drive_conflict, 1'b1);
    edges(1); chk("R5 conflict one cycle", drive_conflict, 1'b0);
  endtask

  task automatic t_irq1;
    @(negedge clk); pin_in[1] = 1'b0;
    edges(2); chk("R6 irq1 before", irq_out[1], 1'b0);
    edges(1); chk("R6 irq1 asserted", irq_out[1], 1'b1);
    @(negedge clk); pin_in[1] = 1'b1;
    edges(3); chk("R6 irq1 released", irq_out[1], 1'b0);
  endtask

  task automatic t_irq9;
    @(negedge clk); pin_in[9] = 1'b1;
    edges(3); chk("R7 irq9 high", irq_out[9], 1'b1);
    @(negedge clk); pin_in[9] = 1'b0;
    edges(3); chk("R7 irq9 low", irq_out[9], 1'b0);
  endtask

  task automatic t_nmi;
    @(negedge clk);
    bus_addr = 6'd17;
    nmi_req = 1'b1;
    edges(1);
    chk("R8 irq9 pulse", irq_out[9], 1'b1);
    chk("R8 pin9 bit1 set", bus_rdata, 8'h02);
    @(negedge clk); nmi_req = 1'b0;
    edges(0);
    @(posedge clk); #1;
    chk("R8 irq9 one cycle", irq_out[9], 1'b0);
    chk("R8 pin9 bit1 back", bus_rdata, 8'h00);
    chk("R9 only line 9 pulsed", irq_out, 10'h0);
  endtask

  task automatic t_write_no_irq;
    logic [7:0] v;
    wr(6'd9, 8'h04); rd(6'd9, v);
    chk("R11 loopback cleared bit1", v, 8'h04);
    edges(1); chk("R11 irq1 unchanged", irq_out[1], 1'b0);
    wr(6'd17, 8'h05);
    edges(1); chk("R11 irq9 unchanged", irq_out[9], 1'b0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    edges(3);
    @(negedge clk) rst_n = 1'b1;
    edges(4);
    t_reset();
    t_window();
    t_write();
    t_input();
    t_conflict();
    t_irq1();
    t_irq9();
    t_nmi();
    t_write_no_irq();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule